// File: doc/BRIEF.md
# Direct-Mapped Four-Word-Line Cache

This block sits between a processor load/store port and a backing memory that moves one 32-bit word per transfer. Each line holds a valid flag, a tag and a four-word data block. A lookup splits the 32-bit address into a tag, a line index and a word select. The byte offset plays no part in the lookup. A valid entry whose tag matches is a hit, and the word select steers one of the four words to the read output in the same cycle.

A read miss holds the processor in a stall. The controller fetches the line from memory one word at a time, starting at word 0 and ending at word 3. It writes the whole block, its tag and its valid flag into the entry in a single cycle. The load then re-runs and hits. Every store is written through to memory. A store that misses first brings its line in, then updates the cached word and sends the store to memory. The processor keeps its request, address, direction and write data steady for as long as the stall output is high.

Top module: `dmc_top`

## Requirements
- R1: The address splits as follows: tag = bits 31 down to INDEX_W+4, line index = bits INDEX_W+3 down to 4, word select = bits 3..2. Bits 1..0 are ignored. With the default INDEX_W of 12 there are 4096 lines and a 16-bit tag.
- R2: A read whose line is valid with a matching tag completes in its first cycle. Stall stays low, the selected word appears on cpu_rdata and no memory request is raised.
- R3: A miss raises stall and performs four memory reads. They use the same tag and index, word selects 0, 1, 2, 3 in that order, and mem_addr bits 1..0 equal to zero.
- R4: After the fourth read word returns, the line is installed with the new tag. The stalled access then re-runs as a hit and a read returns the requested word from that line. Stall stays high from the miss until that cycle.
- R5: A store that hits updates the cached word and makes exactly one memory write. The write uses the word address (bits 1..0 zero) and the store data. Stall stays high until the cycle in which mem_ack is high, and it is low in that cycle.
- R6: A store that misses first refills its line as in R3. It then performs the write of R5. A later read of that word hits and returns the stored value.
- R7: A synchronous reset clears every valid flag, so the first access to any line after reset misses.
- R8: Two addresses that share an index but differ in tag evict each other. Going back to the first address misses again.
- R9: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata steady until the cycle in which mem_ack is high. An acknowledge completes exactly one word transfer.
- R10: Addresses that differ only in byte offset return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when cpu_req is high, cpu_we is low and cpu_stall is low |
| cpu_stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word address for the transfer, bits 1..0 zero |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The bench goes after refill ordering and line assembly. A design that mixed up the refill buffer slots, or installed the line before the last word arrived, would return the wrong word from one of the four positions. Conflicting tags on one index are used to show that a stale tag compare would report hits on evicted lines. A write miss is checked to confirm that allocation happens before the write, so a no-allocate design would miss again on the read-back. Byte-offset variants and a mid-run reset check that the low bits are ignored and that no valid flag survives the reset.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int ADDR_W         = 32;
    localparam int WORD_W         = 32;
    localparam int WORDS_PER_LINE = 4;
    localparam int OFS_W          = $clog2(WORDS_PER_LINE);
    localparam int BYTE_W         = $clog2(WORD_W / 8);
    localparam int LINE_W         = WORD_W * WORDS_PER_LINE;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } ctrl_state_e;

    // Word address inside the line of 'a', word slot replaced by 'w'.
    function automatic logic [ADDR_W-1:0] slot_addr(
        input logic [ADDR_W-1:0] a,
        input logic [OFS_W-1:0]  w
    );
        return {a[ADDR_W-1:OFS_W+BYTE_W], w, {BYTE_W{1'b0}}};
    endfunction
endpackage

// File: rtl/dmc_store.sv
module dmc_store
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 12,
    parameter int TAG_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] idx,
    input  logic [TAG_W-1:0]   tag,
    input  logic [OFS_W-1:0]   wsel,
    output logic               hit,
    output word_t              rd_word,
    input  logic               fill_we,
    input  logic [LINE_W-1:0]  fill_line,
    input  logic               word_we,
    input  word_t              wr_word
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINE_W-1:0] data_q [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINES-1:0]  valid_q;

    always_ff @(posedge clk) begin
        if (rst)          valid_q <= '0;
        else if (fill_we) valid_q[idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            data_q[idx] <= fill_line;
            tag_q[idx]  <= tag;
        end else if (word_we) begin
            data_q[idx][wsel*WORD_W +: WORD_W] <= wr_word;
        end
    end

    logic [LINE_W-1:0] cur_line;
    word_t             line_words [WORDS_PER_LINE];

    assign cur_line = data_q[idx];

    for (genvar g = 0; g < WORDS_PER_LINE; g++) begin : g_word
        assign line_words[g] = cur_line[g*WORD_W +: WORD_W];
    end

    assign rd_word = line_words[wsel];
    assign hit     = valid_q[idx] && (tag_q[idx] == tag);

    AST_RESET_EMPTY: assert property (@(posedge clk)
        $past(rst) |-> !hit);  // R7

    AST_FILL_INSTALLS: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> (hit || !$stable(idx) || !$stable(tag)));  // R4
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic              hit,
    input  logic [OFS_W-1:0]  cpu_wsel,
    output logic              stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [OFS_W-1:0]  mem_wsel,
    input  logic              mem_ack,
    input  word_t             mem_rdata,
    output logic              fill_we,
    output logic [LINE_W-1:0] fill_line,
    output logic              word_we
);
    localparam logic [OFS_W-1:0] LAST = OFS_W'(WORDS_PER_LINE - 1);

    ctrl_state_e      st_q, st_d;
    logic [OFS_W-1:0] cnt_q;
    word_t            buf_q [WORDS_PER_LINE];

    always_comb begin
        st_d    = st_q;
        stall   = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        fill_we = 1'b0;
        word_we = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req && !hit) begin
                    stall = 1'b1;
                    st_d  = ST_FILL;
                end else if (req && we) begin
                    stall   = 1'b1;
                    word_we = 1'b1;
                    st_d    = ST_WRITE;
                end
            end
            ST_FILL: begin
                stall   = 1'b1;
                mem_req = 1'b1;
                if (mem_ack && cnt_q == LAST) begin
                    fill_we = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                stall   = !mem_ack;
                if (mem_ack) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != ST_FILL)  cnt_q <= '0;
            else if (mem_ack)     cnt_q <= cnt_q + OFS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (st_q == ST_FILL && mem_ack && cnt_q != LAST)
            buf_q[cnt_q] <= mem_rdata;
    end

    for (genvar g = 0; g < WORDS_PER_LINE; g++) begin : g_line
        if (g == WORDS_PER_LINE - 1) begin : g_tail
            assign fill_line[g*WORD_W +: WORD_W] = mem_rdata;
        end else begin : g_body
            assign fill_line[g*WORD_W +: WORD_W] = buf_q[g];
        end
    end

    assign mem_wsel = (st_q == ST_FILL) ? cnt_q : cpu_wsel;
endmodule

// File: rtl/dmc_top.sv
module dmc_top
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int IDX_LO = OFS_W + BYTE_W;
    localparam int TAG_LO = IDX_LO + INDEX_W;
    localparam int TAG_W  = ADDR_W - TAG_LO;
    localparam logic [OFS_W-1:0] LAST = OFS_W'(WORDS_PER_LINE - 1);

    logic [INDEX_W-1:0] idx;
    logic [TAG_W-1:0]   tag;
    logic [OFS_W-1:0]   wsel, mem_wsel;
    logic               hit, fill_we, word_we;
    logic [LINE_W-1:0]  fill_line;
    logic [BYTE_W-1:0]  unused_byte_ofs;

    assign tag             = cpu_addr[ADDR_W-1:TAG_LO];
    assign idx             = cpu_addr[TAG_LO-1:IDX_LO];
    assign wsel            = cpu_addr[IDX_LO-1:BYTE_W];
    assign unused_byte_ofs = cpu_addr[BYTE_W-1:0];

    dmc_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .idx       (idx),
        .tag       (tag),
        .wsel      (wsel),
        .hit       (hit),
        .rd_word   (cpu_rdata),
        .fill_we   (fill_we),
        .fill_line (fill_line),
        .word_we   (word_we),
        .wr_word   (cpu_wdata)
    );

    dmc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (cpu_req),
        .we        (cpu_we),
        .hit       (hit),
        .cpu_wsel  (wsel),
        .stall     (cpu_stall),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wsel  (mem_wsel),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .fill_we   (fill_we),
        .fill_line (fill_line),
        .word_we   (word_we)
    );

    assign mem_addr  = slot_addr(cpu_addr, mem_wsel);
    assign mem_wdata = cpu_wdata;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));  // R9

    AST_FILL_SEQ: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack && mem_addr[IDX_LO-1:BYTE_W] != LAST)
        |=> (mem_req && !mem_we
             && mem_addr[IDX_LO-1:BYTE_W] == $past(mem_addr[IDX_LO-1:BYTE_W]) + OFS_W'(1)
             && mem_addr[ADDR_W-1:IDX_LO] == $past(mem_addr[ADDR_W-1:IDX_LO])));  // R3

    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !cpu_stall) |-> (mem_req && mem_we && mem_ack));  // R5

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && !cpu_stall) |-> !mem_req);  // R2
endmodule

// File: tb/tb_dmc_top.sv
module tb_dmc_top;
    localparam int IW  = 3;
    localparam int TW  = 32 - IW - 4;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] wmem [logic [31:0]];
    logic          ref_v [1<<IW];
    logic [TW-1:0] ref_t [1<<IW];
    logic [31:0] log_a [8];
    logic        log_w [8];
    logic [31:0] log_d [8];
    int          log_n = 0;

    always #2 clk = ~clk;

    dmc_top #(.INDEX_W(IW)) dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] mdef(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [31:0] mval(input logic [31:0] a);
        return wmem.exists(a) ? wmem[a] : mdef(a);
    endfunction

    function automatic logic [31:0] mk(input logic [TW-1:0] t, input int i, input int w, input int b);
        return {t, IW'(i), 2'(w), 2'(b)};
    endfunction

    // Backing memory: acknowledges each request LAT cycles after it appears.
    initial begin
        int wc;
        logic [31:0] a0;
        wc = 0;
        a0 = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (wc == 0) a0 = mem_addr;
                wc++;
                if (wc == LAT) begin
                    chk(mem_addr == a0, "R9 address held", mem_addr, a0);
                    wc = 0;
                    mem_ack = 1'b1;
                    if (mem_we) wmem[mem_addr] = mem_wdata;
                    else        mem_rdata = mval(mem_addr);
                    if (log_n < 8) begin
                        log_a[log_n] = mem_addr;
                        log_w[log_n] = mem_we;
                        log_d[log_n] = mem_wdata;
                    end
                    log_n++;
                end
            end
        end
    end

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd, input string rq);
        logic [31:0]   wa;
        int            idx;
        logic [TW-1:0] tg;
        logic          exp_hit;
        int            stall_cyc;
        int            n_exp;
        logic [31:0]   got;
        wa = {a[31:2], 2'b00};
        idx = int'(a[IW+3:4]);
        tg = a[31:IW+4];
        exp_hit = ref_v[idx] && ref_t[idx] == tg;
        stall_cyc = 0;
        @(negedge clk);
        log_n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        while (cpu_stall) begin
            @(negedge clk); #1;
            stall_cyc++;
        end
        got = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0;
        n_exp = (exp_hit ? 0 : 4) + (we ? 1 : 0);
        chk(log_n == n_exp, exp_hit ? "R2 memory transfers on hit" : "R3 memory transfers on miss",
            32'(log_n), 32'(n_exp));
        if (!exp_hit && log_n >= 4) begin
            for (int k = 0; k < 4; k++)
                chk(!log_w[k] && log_a[k] == {a[31:4], 2'(k), 2'b00},
                    we ? "R6 refill before store" : "R3 refill order", log_a[k], {a[31:4], 2'(k), 2'b00});
        end
        if (exp_hit && !we)
            chk(stall_cyc == 0, "R2 no stall on hit", 32'(stall_cyc), 32'd0);
        if (!exp_hit)
            chk(stall_cyc > 0, "R4 stall held through refill", 32'(stall_cyc), 32'd1);
        if (we && log_n == n_exp) begin
            chk(log_w[n_exp-1] && log_a[n_exp-1] == wa, "R5 write-through address", log_a[n_exp-1], wa);
            chk(log_d[n_exp-1] == wd, "R5 write-through data", log_d[n_exp-1], wd);
        end
        if (!we)
            chk(got == mval(wa), rq, got, mval(wa));
        ref_v[idx] = 1'b1;
        ref_t[idx] = tg;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < (1<<IW); i++) ref_v[i] = 1'b0;
    endtask

    localparam logic [TW-1:0] TAG_A = TW'(32'h00AB_CDE);
    localparam logic [TW-1:0] TAG_B = TW'(32'h01F0_F0F);
    localparam logic [TW-1:0] TAG_C = TW'(32'h0000_0A5);

    initial begin
        for (int i = 0; i < (1<<IW); i++) begin ref_v[i] = 1'b0; ref_t[i] = '0; end
        do_reset();
        #1;
        chk(cpu_stall == 1'b0, "R7 reset stall low", 32'(cpu_stall), 32'd0);
        chk(mem_req == 1'b0, "R7 reset no memory request", 32'(mem_req), 32'd0);

        // First touch of every line: miss, refill, correct word (R1, R3, R4).
        for (int i = 0; i < (1<<IW); i++)
            access(1'b0, mk(TAG_A, i, i % 4, (i + 1) % 4), '0, "R1 R4 load after refill");

        // All words, varied byte offsets: hits (R2, R10).
        for (int i = 0; i < (1<<IW); i++)
            for (int w = 0; w < 4; w++)
                access(1'b0, mk(TAG_A, i, w, (i + w) % 4), '0, "R10 byte offset ignored");

        // Store hits, then read back (R5).
        for (int i = 0; i < (1<<IW); i++) begin
            access(1'b1, mk(TAG_A, i, i % 4, 3), 32'hD000_0000 + 32'(i), "R5");
            access(1'b0, mk(TAG_A, i, i % 4, 0), '0, "R5 cache word updated");
        end

        // Same index, other tag, then back (R8).
        for (int i = 0; i < (1<<IW); i++) begin
            access(1'b0, mk(TAG_B, i, 3 - (i % 4), 0), '0, "R8 conflicting tag");
            access(1'b0, mk(TAG_A, i, i % 4, 1), '0, "R8 evicted line refetched");
        end

        // Store misses allocate (R6).
        for (int i = 0; i < 4; i++) begin
            access(1'b1, mk(TAG_C, i, i, 0), 32'hC0DE_0000 + 32'(i), "R6");
            access(1'b0, mk(TAG_C, i, i, 2), '0, "R6 stored word after allocate");
            access(1'b0, mk(TAG_C, i, (i + 1) % 4, 0), '0, "R6 neighbour word after allocate");
        end

        // Reset drops everything (R7).
        do_reset();
        access(1'b0, mk(TAG_C, 0, 0, 0), '0, "R7 miss after reset");
        access(1'b0, mk(TAG_A, 5, 1, 0), '0, "R7 miss after reset");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule